// File: doc/BRIEF.md
# Write Strobe Burst Generator

This block is the controller-side transmit path for a single write burst to a double-data-rate memory. A one-cycle start pulse from the command scheduler hands it the burst's data words and the write latency, which comes from a mode-register setting. The block waits out that latency, then opens the write strobe. It drives the strobe low for half a memory clock as a preamble, launches one data word per strobe edge starting on a rising edge, and holds the strobe low for half a clock as a postamble. After that it releases both the strobe and the data bus.

The block runs on an internal clock at twice the memory clock rate, so one internal cycle is one half memory clock. The pad layer turns the enable outputs into high-impedance control. A burst is `BURST` words long, four by default, to match a 4n-prefetch core. The data words are captured into a small internal buffer on the accepted start. The command path may therefore change its word input at once. A start pulse that arrives while a burst is in flight is reported on an error output and is otherwise dropped.

Top module: `wdqs_burst_gen`

## Requirements
- R1: While reset is asserted, the strobe, both output enables, the data bus, the busy flag and the error flag are all 0.
- R2: If a start is accepted on internal edge E0 with latency WL, the first rising strobe edge appears on internal edge E(2*WL), which is WL memory clocks later. The strobe enable stays 0 before the preamble. A latency of 0 is treated as 1.
- R3: Exactly one internal cycle before the first rising edge, the strobe enable is 1, the strobe is 0 and the data enable is 0. This is the preamble.
- R4: The BURST captured words leave in buffer order, word 0 first, where word i is bits [i*DW +: DW] of the word input. Each word is held for one internal cycle. The strobe is 1 during word 0 and inverts at the start of every following word.
- R5: In the internal cycle after the last word, the strobe enable is 1 and the strobe is 0. This is the postamble. In the cycle after that, both enables are 0 and busy is 0.
- R6: The data enable is 1 only while a word is on the bus. At all other times the data bus reads 0 and is released.
- R7: A start sampled while busy is 1 raises the error flag for exactly one cycle. It does not change the timing or the data of the burst in flight.
- R8: The words are sampled only on the accepted start. Later changes on the word input do not reach the bus during that burst.
- R9: A start sampled in the cycle after the postamble is accepted as a new burst.
- R10: The latency input is sampled only on the accepted start. Changing it during a burst does not move that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle burst request from the scheduler |
| wlat_i | input | WL_W | Write latency in memory clocks, from the mode register |
| words_i | input | BURST*DW | Burst words; word i at bits [i*DW +: DW] |
| dqs_o | output | 1 | Write data strobe |
| dqs_oe_o | output | 1 | Strobe output enable |
| dq_o | output | DW | Write data bus |
| dq_oe_o | output | 1 | Data output enable |
| busy_o | output | 1 | A burst is in flight |
| proto_err_o | output | 1 | Start received while busy (one-cycle pulse) |

## Verification
The bench runs bursts with latencies 0, 1, 2, 3, 7 and 15. A latency of 0 checks the clamp. The smallest latencies check that the preamble can follow the start at once, and the largest checks the wait counter at its top value. The data patterns are incrementing, alternating all-ones/all-zeros, walking-one and mixed words. These show a swapped or repeated beat, and a bus that is stuck or driven when it should be released. The word input and the latency input are changed in every burst just after the start, to show that both are captured. Stray starts are sent once during the latency wait and once in mid-data, and bursts run back to back to show that a start right after the postamble is accepted.

// File: rtl/wdqs_pkg.sv
package wdqs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WAIT = 3'd1,
    PH_PRE  = 3'd2,
    PH_DATA = 3'd3,
    PH_POST = 3'd4
  } wdqs_phase_t;
endpackage

// File: rtl/wdqs_lat_timer.sv
// Counts the internal half-cycles between start and preamble.
module wdqs_lat_timer #(
  parameter int WL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [WL_W-1:0] wlat_i,
  input  logic            dec_i,
  output logic            zero_o
);
  localparam int CW = WL_W + 1;

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [WL_W-1:0] wl_eff;
  logic [CW-1:0]   half_cycles;

  // Latency 0 is clamped to 1 memory clock.
  always_comb begin
    wl_eff      = (wlat_i == '0) ? WL_W'(1) : wlat_i;
    half_cycles = {wl_eff, 1'b0};
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = half_cycles - CW'(2);
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wdqs_burst_buf.sv
// Holds the burst words and launches the selected one onto the bus.
module wdqs_burst_buf #(
  parameter int DW    = 16,
  parameter int BURST = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_i,
  input  logic [BURST*DW-1:0]   words_i,
  input  logic                  drive_i,
  input  logic [$clog2(BURST)-1:0] sel_i,
  output logic [DW-1:0]         dq_o
);
  logic [DW-1:0] slot_q [BURST];
  logic [DW-1:0] dq_d, dq_q;

  for (genvar g = 0; g < BURST; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (cap_i) begin
        slot_q[g] <= words_i[g*DW +: DW];
      end
    end
  end

  always_comb begin
    dq_d = drive_i ? slot_q[sel_i] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= '0;
    end else begin
      dq_q <= dq_d;
    end
  end

  assign dq_o = dq_q;
endmodule

// File: rtl/wdqs_phase_fsm.sv
// Burst sequencer: wait, preamble, data beats, postamble.
module wdqs_phase_fsm
  import wdqs_pkg::*;
#(
  parameter int BURST = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     tmr_zero_i,
  output logic                     tmr_load_o,
  output logic                     tmr_dec_o,
  output logic                     cap_o,
  output logic                     drive_n_o,
  output logic [$clog2(BURST)-1:0] sel_n_o,
  output logic                     dqs_o,
  output logic                     dqs_oe_o,
  output logic                     dq_oe_o,
  output logic                     busy_o,
  output logic                     err_o
);
  localparam int BW = $clog2(BURST);
  localparam logic [BW-1:0] LAST = BW'(BURST - 1);

  wdqs_phase_t ph_q, ph_d;
  logic [BW-1:0] beat_q, beat_d;
  logic dqs_q, dqs_d, sen_q, sen_d, den_q, den_d, err_q, err_d;
  logic accept;

  assign accept = start_i && (ph_q == PH_IDLE);

  // next-state
  always_comb begin
    ph_d       = ph_q;
    beat_d     = beat_q;
    tmr_load_o = 1'b0;
    tmr_dec_o  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d       = PH_WAIT;
          tmr_load_o = 1'b1;
        end
      end
      PH_WAIT: begin
        tmr_dec_o = 1'b1;
        if (tmr_zero_i) begin
          ph_d = PH_PRE;
        end
      end
      PH_PRE: begin
        ph_d   = PH_DATA;
        beat_d = '0;
      end
      PH_DATA: begin
        if (beat_q == LAST) begin
          ph_d = PH_POST;
        end else begin
          beat_d = beat_q + BW'(1);
        end
      end
      PH_POST: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  // next outputs, decoded from the next state so that they leave a flop
  always_comb begin
    sen_d = (ph_d == PH_PRE) || (ph_d == PH_DATA) || (ph_d == PH_POST);
    den_d = (ph_d == PH_DATA);
    dqs_d = den_d && !beat_d[0];
    err_d = start_i && (ph_q != PH_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      beat_q <= '0;
      dqs_q  <= 1'b0;
      sen_q  <= 1'b0;
      den_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      beat_q <= beat_d;
      dqs_q  <= dqs_d;
      sen_q  <= sen_d;
      den_q  <= den_d;
      err_q  <= err_d;
    end
  end

  assign cap_o     = accept;
  assign drive_n_o = den_d;
  assign sel_n_o   = beat_d;
  assign dqs_o     = dqs_q;
  assign dqs_oe_o  = sen_q;
  assign dq_oe_o   = den_q;
  assign busy_o    = (ph_q != PH_IDLE);
  assign err_o     = err_q;
endmodule

// File: rtl/wdqs_burst_gen.sv
module wdqs_burst_gen #(
  parameter int DW    = 16,
  parameter int BURST = 4,
  parameter int WL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [WL_W-1:0]     wlat_i,
  input  logic [BURST*DW-1:0] words_i,
  output logic                dqs_o,
  output logic                dqs_oe_o,
  output logic [DW-1:0]       dq_o,
  output logic                dq_oe_o,
  output logic                busy_o,
  output logic                proto_err_o
);
  localparam int BW = $clog2(BURST);

  logic          tmr_load, tmr_dec, tmr_zero, cap, drive_n;
  logic [BW-1:0] sel_n;

  wdqs_lat_timer #(.WL_W(WL_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .wlat_i (wlat_i),
    .dec_i  (tmr_dec),
    .zero_o (tmr_zero)
  );

  wdqs_phase_fsm #(.BURST(BURST)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_dec_o  (tmr_dec),
    .cap_o      (cap),
    .drive_n_o  (drive_n),
    .sel_n_o    (sel_n),
    .dqs_o      (dqs_o),
    .dqs_oe_o   (dqs_oe_o),
    .dq_oe_o    (dq_oe_o),
    .busy_o     (busy_o),
    .err_o      (proto_err_o)
  );

  wdqs_burst_buf #(.DW(DW), .BURST(BURST)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (cap),
    .words_i (words_i),
    .drive_i (drive_n),
    .sel_i   (sel_n),
    .dq_o    (dq_o)
  );
endmodule

// File: rtl/wdqs_burst_gen_chk.sv
module wdqs_burst_gen_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          dqs_o,
  input logic          dqs_oe_o,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o,
  input logic          busy_o,
  input logic          proto_err_o
);
  a_r6_data_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> dqs_oe_o);

  a_r6_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_o |-> (dq_o == '0));

  a_r3_preamble_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe_o) |-> (!dqs_o && !dq_oe_o));

  a_r4_first_beat_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe_o) |-> dqs_o);

  a_r4_strobe_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe_o && $past(dq_oe_o)) |-> (dqs_o != $past(dqs_o)));

  a_r5_postamble_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe_o) |-> (dqs_oe_o && !dqs_o));

  a_r5_release_after_post: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_oe_o && !dq_oe_o && $past(dq_oe_o)) |=> !dqs_oe_o);

  a_r7_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> proto_err_o);

  a_r7_no_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !proto_err_o);
endmodule

bind wdqs_burst_gen wdqs_burst_gen_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .dqs_o       (dqs_o),
  .dqs_oe_o    (dqs_oe_o),
  .dq_o        (dq_o),
  .dq_oe_o     (dq_oe_o),
  .busy_o      (busy_o),
  .proto_err_o (proto_err_o)
);

// File: tb/wdqs_burst_gen_test.sv
module wdqs_burst_gen_test;
  localparam int DW = 16, BURST = 4, WL_W = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start_i;
  logic [WL_W-1:0]     wlat_i;
  logic [BURST*DW-1:0] words_i;
  logic                dqs_o, dqs_oe_o, dq_oe_o, busy_o, proto_err_o;
  logic [DW-1:0]       dq_o;

  always #4 clk = ~clk;

  wdqs_burst_gen #(.DW(DW), .BURST(BURST), .WL_W(WL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wlat_i(wlat_i),
    .words_i(words_i), .dqs_o(dqs_o), .dqs_oe_o(dqs_oe_o), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .busy_o(busy_o), .proto_err_o(proto_err_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] expq [$];
  logic prev_dqs = 1'b0, prev_den = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every word on the bus is popped from the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dq_oe_o) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4 word with empty scoreboard", 64'(dq_o), 64'h0);
        end else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          chk(dq_o == e, "R4/R8 word order", 64'(dq_o), 64'(e));
        end
        if (!prev_den) chk(dqs_o == 1'b1, "R4 first beat strobe high", 64'(dqs_o), 64'h1);
        else           chk(dqs_o != prev_dqs, "R4 strobe edge per word", 64'(dqs_o), 64'(!prev_dqs));
      end else begin
        chk(dq_o == '0, "R6 bus released outside burst", 64'(dq_o), 64'h0);
      end
      prev_dqs = dqs_o;
      prev_den = dq_oe_o;
    end
  end

  // driver: start a burst, push expected words, check frame timing
  task automatic run_burst(input int wlv, input logic [BURST*DW-1:0] w, input int inj);
    int wle, kend;
    wle  = (wlv == 0) ? 1 : wlv;
    kend = 2*wle + BURST + 1;
    start_i = 1'b1;
    wlat_i  = WL_W'(wlv);
    words_i = w;
    for (int i = 0; i < BURST; i++) expq.push_back(w[i*DW +: DW]);
    @(negedge clk);
    start_i = 1'b0;
    wlat_i  = ~WL_W'(wlv);   // R10: change latency after capture
    for (int k = 0; k <= kend; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1) words_i = ~w; // R8: change words after capture
      if (k == 0) chk(busy_o, "R7 busy after accepted start", 64'(busy_o), 64'h1);
      if (k < 2*wle - 1)
        chk(!dqs_oe_o, "R2/R10 strobe quiet during latency", 64'(dqs_oe_o), 64'h0);
      else if (k == 2*wle - 1)
        chk(dqs_oe_o && !dqs_o && !dq_oe_o, "R3 preamble",
            64'({dqs_oe_o, dqs_o, dq_oe_o}), 64'b100);
      else if (k == 2*wle)
        chk(dqs_oe_o && dqs_o && dq_oe_o, "R2 first rising edge at latency",
            64'({dqs_oe_o, dqs_o, dq_oe_o}), 64'b111);
      else if (k == 2*wle + BURST)
        chk(dqs_oe_o && !dqs_o && !dq_oe_o, "R5 postamble",
            64'({dqs_oe_o, dqs_o, dq_oe_o}), 64'b100);
      else if (k == kend)
        chk(!dqs_oe_o && !dq_oe_o && !busy_o, "R5 strobe released",
            64'({dqs_oe_o, dq_oe_o, busy_o}), 64'b000);
      if (inj >= 0 && k == inj + 1) begin
        chk(proto_err_o, "R7 error on start while busy", 64'(proto_err_o), 64'h1);
        start_i = 1'b0;
      end
      if (inj >= 0 && k == inj + 2)
        chk(!proto_err_o, "R7 error is one cycle", 64'(proto_err_o), 64'h0);
      if (inj >= 0 && k == inj) start_i = 1'b1;
    end
    chk(expq.size() == 0, "R4 all words sent", 64'(expq.size()), 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    start_i = 1'b0;
    wlat_i  = '0;
    words_i = '0;
    repeat (3) @(negedge clk);
    chk({dqs_o, dqs_oe_o, dq_oe_o, busy_o, proto_err_o} == '0 && dq_o == '0,
        "R1 reset state", 64'({dqs_o, dqs_oe_o, dq_oe_o, busy_o, proto_err_o, dq_o}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    run_burst(1,  64'h0004_0003_0002_0001, -1);
    run_burst(3,  64'hFFFF_0000_FFFF_0000, -1);  // R9 back to back
    run_burst(0,  64'hA5A5_5A5A_1234_8001, -1);  // R2 clamp of latency 0
    run_burst(7,  64'h8000_4000_2000_1000, 5);   // R7 stray start while waiting
    run_burst(2,  64'hDEAD_BEEF_CAFE_F00D, 5);   // R7 stray start during data
    run_burst(15, 64'h0001_0002_0004_0008, -1);
    repeat (4) @(negedge clk);
    chk(!busy_o && !dqs_oe_o, "R9 idle after last burst", 64'({busy_o, dqs_oe_o}), 64'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule